// File: doc/BRIEF.md
# Serial Register Access Port

This block lets a host reach a sixteen-entry byte register file, for example a timekeeping core, over a four-wire serial link in mode 0. The bus lines are asynchronous to the system clock. Each one passes through a short synchronizer, and SCK edges are found as transitions of the sampled signal. Because of this, the SCK period must be many system clocks long.

A transaction begins when chip select falls. The first byte is a command. A set top bit asks for a read, and a write is accepted only when the whole upper nibble is zero. The low nibble gives the first register. Any number of data bytes may follow. The register index steps by one after every data byte and wraps around the sixteen entries. Writes leave as single-cycle strobes carrying address and data. Reads issue a single-cycle strobe, and the register file returns the byte in that same cycle. That byte is then shifted out on MISO.

Top module: `spi_regport`

## Requirements
- R1: After reset, MISO is low, neither strobe is active and the register address output is 0.
- R2: A command byte with bit 7 = 1 starts a read burst at the address in bits 3:0, whatever bits 6:4 hold.
- R3: A command byte with bit 7 = 0 and any of bits 6:4 set is rejected. No strobe is produced until chip select is released.
- R4: In a write burst (command bits 7:4 = 0), every completed data byte produces one reg_wr pulse with the current address and the byte. MOSI is sampled on rising SCK, MSB first.
- R5: The register address steps by one after each data byte and wraps from 0xF to 0x0.
- R6: In a read burst, a reg_rd pulse is issued when each data byte begins: one after the command byte and one after each data byte, so n data bytes give n+1 pulses. The byte present on reg_rdata in that cycle is shifted out MSB first, and MISO changes only after falling SCK edges. MISO is 0 during the command byte.
- R7: Raising chip select aborts the transaction. A partly received byte produces no strobe, and the next transaction starts again with a command byte.
- R8: Command 0x00 followed by seven bytes writes registers 0x0..0x6 in order. Command 0x80 followed by seven dummy bytes returns registers 0x0..0x6 in order.
- R9: reg_wr and reg_rd are never active together, and each is a pulse of one clock cycle.
- R10: While chip select stays high, MISO is low and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| reg_addr | output | 4 | Register index for the current strobe |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 8 | Read data, valid in the cycle reg_rd is high |

## Verification
A bit counter that has drifted, or an address that has slipped, shows up at the ports within one byte time. The next strobe then carries the wrong index or the wrong data, or a byte arrives on MISO shifted by one position. A phase register that has not returned to the command state after an abort makes the first byte of the next transaction be taken as data, which gives an unexpected write strobe about eight SCK periods later. The bench predicts every strobe and every MISO bit from its own model of the register contents, and compares them against the design on every clock.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_SKIP} phase_t;

  logic [SYNC_STAGES-1:0] sck_sy, cs_sy, mosi_sy;
  logic                   sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
      sck_d   <= 1'b0;
    end else begin
      sck_sy  <= {sck_sy[SYNC_STAGES-2:0], sck};
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi};
      sck_d   <= sck_sy[SYNC_STAGES-1];
    end
  end

  wire sck_s  = sck_sy[SYNC_STAGES-1];
  wire sel    = ~cs_sy[SYNC_STAGES-1];
  wire mosi_s = mosi_sy[SYNC_STAGES-1];
  wire rise   = sel & sck_s & ~sck_d;
  wire fall   = sel & ~sck_s & sck_d;

  phase_t            ph;
  logic [CW-1:0]     bcnt;
  logic [DATA_W-2:0] shin;
  logic [ADDR_W-1:0] addr, addr_q;
  logic [DATA_W-1:0] tx, wdata_q;
  logic              miso_q, wr_q, rd_q;

  wire              byte_done = rise & (bcnt == LAST_BIT);
  wire [DATA_W-1:0] inb       = {shin, mosi_s};
  wire              cmd_rd    = inb[DATA_W-1];
  wire              cmd_wr_ok = (inb[DATA_W-1:ADDR_W] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_CMD;
      bcnt    <= '0;
      shin    <= '0;
      addr    <= '0;
      addr_q  <= '0;
      tx      <= '0;
      wdata_q <= '0;
      miso_q  <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (!sel) begin
        ph     <= PH_CMD;
        bcnt   <= '0;
        tx     <= '0;
        miso_q <= 1'b0;
      end else begin
        if (rise) begin
          shin <= {shin[DATA_W-3:0], mosi_s};
          bcnt <= bcnt + 1'b1;
        end
        if (byte_done) begin
          case (ph)
            PH_CMD: begin
              if (cmd_rd) begin
                ph     <= PH_RD;
                rd_q   <= 1'b1;
                addr_q <= inb[ADDR_W-1:0];
                addr   <= inb[ADDR_W-1:0] + 1'b1;
              end else if (cmd_wr_ok) begin
                ph   <= PH_WR;
                addr <= inb[ADDR_W-1:0];
              end else begin
                ph <= PH_SKIP;
              end
            end
            PH_WR: begin
              wr_q    <= 1'b1;
              addr_q  <= addr;
              wdata_q <= inb;
              addr    <= addr + 1'b1;
            end
            PH_RD: begin
              rd_q   <= 1'b1;
              addr_q <= addr;
              addr   <= addr + 1'b1;
            end
            default: ph <= PH_SKIP;
          endcase
        end
        if (rd_q) begin
          tx <= reg_rdata;
        end else if (fall) begin
          miso_q <= tx[DATA_W-1];
          tx     <= {tx[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso      = miso_q;
  assign reg_addr  = addr_q;
  assign reg_wr    = wr_q;
  assign reg_wdata = wdata_q;
  assign reg_rd    = rd_q;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int ADDR_W = 4,
  parameter int QUIET  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              miso,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr
);
  logic [7:0]        idle_cnt;
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;
  wire               strobe = reg_wr | reg_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else begin
      if (!cs_n) idle_cnt <= '0;
      else if (idle_cnt < 8'(QUIET)) idle_cnt <= idle_cnt + 1'b1;
      if (cs_n) have_prev <= 1'b0;
      else if (strobe) have_prev <= 1'b1;
      if (strobe) prev_addr <= reg_addr;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd)); // R9
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R9
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (idle_cnt == 8'(QUIET)) |-> (!miso && !strobe)); // R10
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (strobe && have_prev) |-> (reg_addr == prev_addr + 1'b1)); // R5
endmodule

bind spi_regport spi_regport_chk #(.ADDR_W(ADDR_W), .QUIET(SYNC_STAGES + 3)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr)
);

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, reg_wr, reg_rd;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [16];
  logic [7:0] shadow [16];
  logic [7:0] txb [16];
  logic [7:0] rxb [16];

  typedef struct { bit rd; logic [3:0] a; logic [7:0] d; string tag; } ev_t;
  ev_t expq[$];
  ev_t cur;
  int checks = 0, fails = 0;
  localparam time HALF = 160ns;

  spi_regport u_spi_regport (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata)
  );

  always #10ns clk = ~clk;
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (reg_wr || reg_rd)) begin
      if (reg_wr && reg_rd) chk(0, "R9", "both strobes", 1, 0);
      else if (expq.size() == 0) chk(0, "R3", "unexpected strobe at addr", int'(reg_addr), -1);
      else begin
        cur = expq.pop_front();
        chk(cur.rd == reg_rd, cur.tag, "strobe kind rd", int'(reg_rd), int'(cur.rd));
        chk(reg_addr == cur.a, cur.tag, "strobe addr", int'(reg_addr), int'(cur.a));
        if (!cur.rd) chk(reg_wdata == cur.d, cur.tag, "write data", int'(reg_wdata), int'(cur.d));
      end
    end
  end

  task automatic push(bit rd, logic [3:0] a, logic [7:0] d, string tag);
    ev_t e;
    e.rd = rd; e.a = a; e.d = d; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic spi_txn(int nb, int tail_bits, string tag);
    cs_n = 1'b0;
    #HALF;
    for (int b = 0; b < nb; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = txb[b][i];
        #HALF sck = 1'b1;
        rxb[b][i] = miso;
        #HALF sck = 1'b0;
      end
    end
    for (int i = 0; i < tail_bits; i++) begin
      mosi = 1'b1;
      #HALF sck = 1'b1;
      #HALF sck = 1'b0;
    end
    #HALF cs_n = 1'b1;
    mosi = 1'b0;
    #400ns;
    chk(miso == 1'b0, "R10", "miso while deselected", int'(miso), 0);
    chk(expq.size() == 0, tag, "strobes still pending", expq.size(), 0);
    expq.delete();
  endtask

  task automatic wr_burst(logic [3:0] start, int n, string tag);
    txb[0] = {4'h0, start};
    for (int i = 0; i < n; i++) begin
      logic [3:0] a = start + 4'(i);
      txb[i+1] = {start, 4'(i)} ^ 8'h5A ^ 8'(checks);
      push(1'b0, a, txb[i+1], tag);
      shadow[a] = txb[i+1];
    end
    spi_txn(n + 1, 0, tag);
    chk(rxb[0] == 8'h00, "R6", "miso during command", int'(rxb[0]), 0);
  endtask

  task automatic rd_burst(logic [7:0] cmd, int n, string tag);
    txb[0] = cmd;
    for (int i = 0; i <= n; i++) push(1'b1, cmd[3:0] + 4'(i), 8'h00, tag);
    for (int i = 1; i <= n; i++) txb[i] = 8'hFF;
    spi_txn(n + 1, 0, tag);
    chk(rxb[0] == 8'h00, "R6", "miso during command", int'(rxb[0]), 0);
    for (int i = 0; i < n; i++)
      chk(rxb[i+1] == shadow[cmd[3:0] + 4'(i)], tag, "read byte", int'(rxb[i+1]),
          int'(shadow[cmd[3:0] + 4'(i)]));
  endtask

  initial begin
    #(200000 * 20ns);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'hA0 + 8'(i);
      shadow[i] = 8'hA0 + 8'(i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miso == 1'b0, "R1", "miso after reset", int'(miso), 0);
    chk(!reg_wr && !reg_rd, "R1", "strobes after reset", int'({reg_wr, reg_rd}), 0);
    chk(reg_addr == 4'h0, "R1", "addr after reset", int'(reg_addr), 0);
    repeat (20) @(negedge clk);
    chk(miso == 1'b0 && !reg_wr && !reg_rd, "R10", "idle outputs", int'(miso), 0);

    wr_burst(4'h0, 7, "R8");            // R4 write path, R8 seven-byte load
    rd_burst(8'h80, 7, "R8");           // R6 read path, R8 seven-byte read
    wr_burst(4'hE, 4, "R5");            // R5 wrap during write
    rd_burst(8'hFF, 3, "R2");           // R2 bits 6:4 ignored, R5 wrap on read

    txb[0] = 8'h30; txb[1] = 8'h12; txb[2] = 8'h34;
    spi_txn(3, 0, "R3");                // R3 rejected write command
    rd_burst(8'h80, 2, "R3");

    txb[0] = 8'h05; txb[1] = 8'hC3;
    push(1'b0, 4'h5, 8'hC3, "R7");
    shadow[5] = 8'hC3;
    spi_txn(2, 4, "R7");                // R7 partial byte dropped
    rd_burst(8'h85, 2, "R7");

    txb[0] = 8'h82;
    push(1'b1, 4'h2, 8'h00, "R7");
    spi_txn(1, 5, "R7");                // R7 read aborted mid-byte
    wr_burst(4'h9, 2, "R7");
    rd_burst(8'h89, 2, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule